// File: doc/BRIEF.md
# BERT Receive Synchronizer and Counters

This block is the receive half of a bit error rate tester. Each cycle in which the bit enable is high, it takes one serial bit. The bit comes from the external receive line, or from the local transmit stream when loopback is selected. The block keeps the newest 32 received bits in a history register. A self-seeding reference generator learns the incoming pattern from that history and then predicts each following bit. Once the prediction has held for 32 bits in a row, the block declares lock. While locked it counts received bits and mismatching bits in two saturating counters.

Software or external pins drive the control strobes. The count strobe copies both counters into readable holding registers and restarts the internal counts from zero. The capture strobe snapshots the bit history. A manual resync strobe forces the synchronizer back into acquisition at any time. An automatic resync, which can be switched off, drops lock when too many errors fall inside a 64-bit window. Two pattern kinds are supported: a 2^20-1 pseudorandom sequence, and any pattern that repeats every 32 bits.

Top module: `bert_rx_core`

## Requirements
- R1: With `loopback_i` high the received bit is `tx_data_i` and `rx_data_i` has no effect. With `loopback_i` low the received bit is `rx_data_i` and `tx_data_i` has no effect.
- R2: On a rising edge of (`load_ctl_reg_i` OR `load_ctl_pin_i`), `rx_capture_o` takes the 32 bits received before that cycle. Bit 0 is the newest bit. At all other times `rx_capture_o` holds its value.
- R3: On a rising edge of (`latch_ctl_reg_i` OR `latch_ctl_pin_i`), `bit_count_o` and `err_count_o` take the internal bit and error counts, and the internal counts restart from zero.
- R4: A control whose ORed level stays high acts only once. It must return low and rise again to act a second time, whichever of its two sources is raised.
- R5: With `prbs_sel_i` high the pattern follows s[n] = s[n-17] XOR s[n-20]. After reset or a resync, the first 20 enabled bits seed the reference. `in_sync_o` rises after the 52nd bit, once the following 32 bits have all matched. Any mismatch before lock restarts the acquisition.
- R6: With `prbs_sel_i` low the pattern is any sequence that repeats every 32 bits. 32 bits seed the reference and 32 matching bits follow, so `in_sync_o` rises after the 64th bit.
- R7: Only bits received while locked are counted. A bit counts as an error when it differs from the reference's prediction. The error count never exceeds the bit count.
- R8: The internal counters are CNT_W bits wide (32 by default) and stop at all-ones instead of wrapping.
- R9: With `auto_resync_dis_i` low, the 6th error inside a 64-bit window drops lock on that bit and restarts acquisition. Windows are aligned to the moment of lock. With `auto_resync_dis_i` high, errors never drop lock.
- R10: A rising edge of `resync_ctl_i` drops lock in the next cycle and restarts acquisition.
- R11: After reset, `in_sync_o` is low and `bit_count_o`, `err_count_o` and `rx_capture_o` are zero. `in_sync_o` is high exactly while the synchronizer is locked.
- R12: While `bit_en_i` is low, no bit is taken. The history, the reference, the synchronizer state and the internal counts do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en_i | input | 1 | Takes one received bit this cycle |
| rx_data_i | input | 1 | External serial receive bit |
| tx_data_i | input | 1 | Local transmit bit, used as the received bit in loopback |
| loopback_i | input | 1 | 1 selects the transmit stream as the received bit |
| prbs_sel_i | input | 1 | 1 selects the pseudorandom pattern, 0 selects a 32-bit repeating pattern |
| auto_resync_dis_i | input | 1 | 1 disables automatic resync, 0 enables it |
| resync_ctl_i | input | 1 | Rising edge forces reacquisition |
| latch_ctl_reg_i | input | 1 | Count latch control, register source |
| latch_ctl_pin_i | input | 1 | Count latch control, pin source |
| load_ctl_reg_i | input | 1 | History capture control, register source |
| load_ctl_pin_i | input | 1 | History capture control, pin source |
| in_sync_o | output | 1 | High while locked |
| bit_count_o | output | CNT_W | Latched bit count |
| err_count_o | output | CNT_W | Latched error count |
| rx_capture_o | output | 32 | Captured receive history, bit 0 newest |

## Verification
The assertions take it for granted that every control input changes only between clock edges and is synchronous to `clk`. The count-clear property only covers latch edges that arrive on a cycle with `bit_en_i` low. The stimulus follows these rules. Every input is driven at the falling edge. Each strobe is raised and lowered only on cycles where the bit enable is low. The pseudorandom source starts from a nonzero state, so the reference can never seed to all zeros on a good line.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;

  typedef enum logic [1:0] {
    SY_ACQ    = 2'd0,
    SY_VERIFY = 2'd1,
    SY_LOCKED = 2'd2
  } sync_state_e;

  localparam int unsigned CTL_LATCH  = 0;
  localparam int unsigned CTL_LOAD   = 1;
  localparam int unsigned CTL_RESYNC = 2;
  localparam int unsigned CTL_NUM    = 3;

endpackage

// File: rtl/bert_rst_sync.sv
module bert_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = pipe_q[STAGES-1];

endmodule

// File: rtl/bert_edge_det.sv
module bert_edge_det #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_a,
  input  logic [N-1:0] lvl_b,
  output logic [N-1:0] rise
);

  for (genvar i = 0; i < N; i++) begin : g_ctl
    logic lvl;
    logic prev_q;

    assign lvl = lvl_a[i] | lvl_b[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
      end else begin
        prev_q <= lvl;
      end
    end

    assign rise[i] = lvl & ~prev_q;
  end

endmodule

// File: rtl/bert_rx_ref.sv
module bert_rx_ref #(
  parameter int unsigned HIST_W   = 32,
  parameter int unsigned PRBS_LEN = 20,
  parameter int unsigned PRBS_TAP = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_in,
  input  logic              prbs_sel,
  input  logic              seed,
  output logic [HIST_W-1:0] hist_q,
  output logic              predict
);

  logic [HIST_W-1:0] hist_nxt;
  logic [HIST_W-1:0] ref_q;
  logic [HIST_W-1:0] ref_nxt;

  // history: bit 0 is the newest received bit
  always_comb begin
    hist_nxt = {hist_q[HIST_W-2:0], rx_in};
  end

  // reference predictor: free-running after seeding
  always_comb begin
    if (prbs_sel) begin
      predict = ref_q[PRBS_TAP-1] ^ ref_q[PRBS_LEN-1];
    end else begin
      predict = ref_q[HIST_W-1];
    end
    if (seed) begin
      ref_nxt = hist_nxt;
    end else begin
      ref_nxt = {ref_q[HIST_W-2:0], predict};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      ref_q  <= '0;
    end else if (bit_en) begin
      hist_q <= hist_nxt;
      ref_q  <= ref_nxt;
    end
  end

endmodule

// File: rtl/bert_sync_fsm.sv
module bert_sync_fsm
  import bert_rx_pkg::*;
#(
  parameter int unsigned HIST_W    = 32,
  parameter int unsigned PRBS_LEN  = 20,
  parameter int unsigned LOCK_BITS = 32,
  parameter int unsigned WIN_BITS  = 64,
  parameter int unsigned ERR_LIMIT = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic        prbs_sel,
  input  logic        mismatch,
  input  logic        auto_dis,
  input  logic        force_resync,
  output sync_state_e state_q,
  output logic        seed,
  output logic        count_en
);

  localparam int unsigned FILL_W  = $clog2(HIST_W) + 1;
  localparam int unsigned MATCH_W = $clog2(LOCK_BITS) + 1;
  localparam int unsigned WIN_W   = $clog2(WIN_BITS) + 1;
  localparam int unsigned ERR_W   = $clog2(ERR_LIMIT + 1) + 1;

  localparam logic [FILL_W-1:0]  FILL_PRBS_LAST = FILL_W'(PRBS_LEN - 1);
  localparam logic [FILL_W-1:0]  FILL_REP_LAST  = FILL_W'(HIST_W - 1);
  localparam logic [MATCH_W-1:0] MATCH_LAST     = MATCH_W'(LOCK_BITS - 1);
  localparam logic [WIN_W-1:0]   WIN_LAST       = WIN_W'(WIN_BITS - 1);
  localparam logic [ERR_W-1:0]   ERR_LIM        = ERR_W'(ERR_LIMIT);

  sync_state_e        state_nxt;
  logic [FILL_W-1:0]  fill_q,  fill_nxt;
  logic [MATCH_W-1:0] match_q, match_nxt;
  logic [WIN_W-1:0]   win_q,   win_nxt;
  logic [ERR_W-1:0]   werr_q,  werr_nxt;
  logic [FILL_W-1:0]  fill_last;
  logic [ERR_W-1:0]   werr_sum;

  always_comb begin
    fill_last = prbs_sel ? FILL_PRBS_LAST : FILL_REP_LAST;
    werr_sum  = werr_q + {{(ERR_W-1){1'b0}}, mismatch};
  end

  always_comb begin
    state_nxt = state_q;
    fill_nxt  = fill_q;
    match_nxt = match_q;
    win_nxt   = win_q;
    werr_nxt  = werr_q;
    seed      = 1'b0;
    if (force_resync) begin
      state_nxt = SY_ACQ;
      fill_nxt  = '0;
      match_nxt = '0;
      win_nxt   = '0;
      werr_nxt  = '0;
    end else if (bit_en) begin
      unique case (state_q)
        SY_ACQ: begin
          if (fill_q == fill_last) begin
            seed      = 1'b1;
            state_nxt = SY_VERIFY;
            fill_nxt  = '0;
            match_nxt = '0;
          end else begin
            fill_nxt = fill_q + 1'b1;
          end
        end
        SY_VERIFY: begin
          if (mismatch) begin
            state_nxt = SY_ACQ;
            fill_nxt  = '0;
          end else if (match_q == MATCH_LAST) begin
            state_nxt = SY_LOCKED;
            win_nxt   = '0;
            werr_nxt  = '0;
          end else begin
            match_nxt = match_q + 1'b1;
          end
        end
        SY_LOCKED: begin
          if (!auto_dis && (werr_sum >= ERR_LIM)) begin
            state_nxt = SY_ACQ;
            fill_nxt  = '0;
            match_nxt = '0;
            win_nxt   = '0;
            werr_nxt  = '0;
          end else if (win_q == WIN_LAST) begin
            win_nxt  = '0;
            werr_nxt = '0;
          end else begin
            win_nxt  = win_q + 1'b1;
            werr_nxt = (werr_sum > ERR_LIM) ? ERR_LIM : werr_sum;
          end
        end
        default: begin
          state_nxt = SY_ACQ;
          fill_nxt  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SY_ACQ;
      fill_q  <= '0;
      match_q <= '0;
      win_q   <= '0;
      werr_q  <= '0;
    end else begin
      state_q <= state_nxt;
      fill_q  <= fill_nxt;
      match_q <= match_nxt;
      win_q   <= win_nxt;
      werr_q  <= werr_nxt;
    end
  end

  assign count_en = bit_en & (state_q == SY_LOCKED) & ~force_resync;

endmodule

// File: rtl/bert_bit_counters.sv
module bert_bit_counters #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             mismatch,
  input  logic             latch,
  output logic [CNT_W-1:0] bit_run_q,
  output logic [CNT_W-1:0] err_run_q,
  output logic [CNT_W-1:0] bit_hold_q,
  output logic [CNT_W-1:0] err_hold_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             bit_inc, err_inc;
  logic [CNT_W-1:0] bit_run_nxt, err_run_nxt;

  always_comb begin
    bit_inc = count_en & (bit_run_q != '1);
    err_inc = count_en & mismatch & (err_run_q != '1);
    if (latch) begin
      bit_run_nxt = bit_inc ? ONE : '0;
      err_run_nxt = err_inc ? ONE : '0;
    end else begin
      bit_run_nxt = bit_run_q + (bit_inc ? ONE : '0);
      err_run_nxt = err_run_q + (err_inc ? ONE : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_run_q <= '0;
      err_run_q <= '0;
    end else begin
      bit_run_q <= bit_run_nxt;
      err_run_q <= err_run_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_hold_q <= '0;
      err_hold_q <= '0;
    end else if (latch) begin
      bit_hold_q <= bit_run_q;
      err_hold_q <= err_run_q;
    end
  end

endmodule

// File: rtl/bert_rx_core.sv
module bert_rx_core
  import bert_rx_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned HIST_W    = 32,
  parameter int unsigned PRBS_LEN  = 20,
  parameter int unsigned PRBS_TAP  = 17,
  parameter int unsigned LOCK_BITS = 32,
  parameter int unsigned WIN_BITS  = 64,
  parameter int unsigned ERR_LIMIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en_i,
  input  logic              rx_data_i,
  input  logic              tx_data_i,
  input  logic              loopback_i,
  input  logic              prbs_sel_i,
  input  logic              auto_resync_dis_i,
  input  logic              resync_ctl_i,
  input  logic              latch_ctl_reg_i,
  input  logic              latch_ctl_pin_i,
  input  logic              load_ctl_reg_i,
  input  logic              load_ctl_pin_i,
  output logic              in_sync_o,
  output logic [CNT_W-1:0]  bit_count_o,
  output logic [CNT_W-1:0]  err_count_o,
  output logic [HIST_W-1:0] rx_capture_o
);

  logic               rst_sync_n;
  logic               rx_in;
  logic [CTL_NUM-1:0] ctl_a, ctl_b, rise_vec;
  logic               latch_rise, load_rise, resync_rise;
  logic [HIST_W-1:0]  hist_q;
  logic               predict, mismatch, seed, count_en;
  sync_state_e        state;
  logic [CNT_W-1:0]   bit_run, err_run;
  logic [HIST_W-1:0]  cap_q;

  bert_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign rx_in = loopback_i ? tx_data_i : rx_data_i;

  always_comb begin
    ctl_a             = '0;
    ctl_b             = '0;
    ctl_a[CTL_LATCH]  = latch_ctl_reg_i;
    ctl_b[CTL_LATCH]  = latch_ctl_pin_i;
    ctl_a[CTL_LOAD]   = load_ctl_reg_i;
    ctl_b[CTL_LOAD]   = load_ctl_pin_i;
    ctl_a[CTL_RESYNC] = resync_ctl_i;
  end

  bert_edge_det #(.N(CTL_NUM)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lvl_a (ctl_a),
    .lvl_b (ctl_b),
    .rise  (rise_vec)
  );

  assign latch_rise  = rise_vec[CTL_LATCH];
  assign load_rise   = rise_vec[CTL_LOAD];
  assign resync_rise = rise_vec[CTL_RESYNC];

  bert_rx_ref #(
    .HIST_W   (HIST_W),
    .PRBS_LEN (PRBS_LEN),
    .PRBS_TAP (PRBS_TAP)
  ) u_ref (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bit_en   (bit_en_i),
    .rx_in    (rx_in),
    .prbs_sel (prbs_sel_i),
    .seed     (seed),
    .hist_q   (hist_q),
    .predict  (predict)
  );

  assign mismatch = rx_in ^ predict;

  bert_sync_fsm #(
    .HIST_W    (HIST_W),
    .PRBS_LEN  (PRBS_LEN),
    .LOCK_BITS (LOCK_BITS),
    .WIN_BITS  (WIN_BITS),
    .ERR_LIMIT (ERR_LIMIT)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .bit_en       (bit_en_i),
    .prbs_sel     (prbs_sel_i),
    .mismatch     (mismatch),
    .auto_dis     (auto_resync_dis_i),
    .force_resync (resync_rise),
    .state_q      (state),
    .seed         (seed),
    .count_en     (count_en)
  );

  bert_bit_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .count_en   (count_en),
    .mismatch   (mismatch),
    .latch      (latch_rise),
    .bit_run_q  (bit_run),
    .err_run_q  (err_run),
    .bit_hold_q (bit_count_o),
    .err_hold_q (err_count_o)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cap_q <= '0;
    end else if (load_rise) begin
      cap_q <= hist_q;
    end
  end

  assign rx_capture_o = cap_q;
  assign in_sync_o    = (state == SY_LOCKED);

endmodule

// File: rtl/bert_rx_checker.sv
module bert_rx_checker #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned HIST_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              in_sync,
  input logic              latch_rise,
  input logic              load_rise,
  input logic              resync_rise,
  input logic [CNT_W-1:0]  bit_run,
  input logic [CNT_W-1:0]  err_run,
  input logic [HIST_W-1:0] capture
);

  // R2: capture only moves on a load edge
  p_capture_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rise |=> $stable(capture));

  // R3: a latch edge on an idle bit cycle leaves the internal counts at zero
  p_latch_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_rise && !bit_en) |=> (bit_run == '0 && err_run == '0));

  // R7: nothing counted while unlocked
  p_unlocked_nocount_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sync && !latch_rise) |=> ($stable(bit_run) && $stable(err_run)));

  // R7: errors are a subset of counted bits
  p_err_le_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_run <= bit_run);

  // R8: a full counter stays full until latched
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bit_run == '1) && !latch_rise) |=> (bit_run == '1));

  // R10: manual resync drops lock
  p_manual_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resync_rise |=> !in_sync);

  // R12: no bit taken while the enable is low
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !latch_rise && !resync_rise) |=> ($stable(bit_run) && $stable(in_sync)));

endmodule

bind bert_rx_core bert_rx_checker #(.CNT_W(CNT_W), .HIST_W(HIST_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .bit_en      (bit_en_i),
  .in_sync     (in_sync_o),
  .latch_rise  (latch_rise),
  .load_rise   (load_rise),
  .resync_rise (resync_rise),
  .bit_run     (bit_run),
  .err_run     (err_run),
  .capture     (cap_q)
);

// File: tb/test_bert_rx_core.sv
`timescale 1ns/1ps
module test_bert_rx_core;

  localparam int CW = 8;

  logic clk, rst_n, bit_en_i, rx_data_i, tx_data_i, loopback_i, prbs_sel_i;
  logic auto_resync_dis_i, resync_ctl_i, latch_ctl_reg_i, latch_ctl_pin_i;
  logic load_ctl_reg_i, load_ctl_pin_i, in_sync_o;
  logic [CW-1:0] bit_count_o, err_count_o;
  logic [31:0]   rx_capture_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [19:0] gen_q;
  logic [31:0] sent_hist;
  logic [31:0] rep_word = 32'hF0E1_2C35;
  int          rep_idx;

  bert_rx_core #(.CNT_W(CW)) i_bert_rx_core (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_en_i = 0; rx_data_i = 0; tx_data_i = 0; loopback_i = 0;
    prbs_sel_i = 1; auto_resync_dis_i = 0; resync_ctl_i = 0;
    latch_ctl_reg_i = 0; latch_ctl_pin_i = 0; load_ctl_reg_i = 0; load_ctl_pin_i = 0;
    gen_q = 20'h5A3C1; sent_hist = '0; rep_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // drive one bit on the selected path, the other path carries its inverse
  task automatic send_line(logic b);
    @(negedge clk);
    bit_en_i = 1'b1;
    if (loopback_i) begin tx_data_i = b; rx_data_i = ~b; end
    else            begin rx_data_i = b; tx_data_i = ~b; end
    sent_hist = {sent_hist[30:0], b};
  endtask

  task automatic send_prbs(int n, int nerr);
    for (int i = 0; i < n; i++) begin
      logic nb;
      nb = gen_q[16] ^ gen_q[19];
      gen_q = {gen_q[18:0], nb};
      send_line(nb ^ (i < nerr));
    end
  endtask

  task automatic send_rep(int n);
    for (int i = 0; i < n; i++) begin
      send_line(rep_word[31 - rep_idx]);
      rep_idx = (rep_idx + 1) % 32;
    end
  endtask

  task automatic settle();
    @(negedge clk);
    bit_en_i = 1'b0;
  endtask

  task automatic latch(bit use_pin, string req, int exp_bits, int exp_errs);
    settle();
    if (use_pin) latch_ctl_pin_i = 1'b1; else latch_ctl_reg_i = 1'b1;
    @(negedge clk);
    check(req, "bit_count", 32'(bit_count_o), 32'(exp_bits));
    check(req, "err_count", 32'(err_count_o), 32'(exp_errs));
    latch_ctl_pin_i = 1'b0; latch_ctl_reg_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R11", "in_sync after reset", 32'(in_sync_o), 0);
    check("R11", "bit_count after reset", 32'(bit_count_o), 0);
    check("R11", "err_count after reset", 32'(err_count_o), 0);
    check("R11", "capture after reset", rx_capture_o, 0);
  endtask

  task automatic t_prbs_latch();
    do_reset();
    send_prbs(51, 0); settle();
    check("R5", "no lock after 51 bits", 32'(in_sync_o), 0);
    send_prbs(1, 0); settle();
    check("R5", "lock after 52 bits", 32'(in_sync_o), 1);
    send_prbs(100, 0);
    latch(1, "R3", 100, 0);
    send_prbs(10, 0);
    latch(0, "R3", 10, 0);
    // R4: level already high via reg, adding pin is no new edge
    settle(); latch_ctl_reg_i = 1'b1; @(negedge clk);
    check("R4", "first edge latched", 32'(bit_count_o), 0);
    latch_ctl_pin_i = 1'b1;
    send_prbs(7, 0); settle(); @(negedge clk);
    check("R4", "held level no relatch", 32'(bit_count_o), 0);
    latch_ctl_pin_i = 0; latch_ctl_reg_i = 0; @(negedge clk);
    latch(1, "R4", 7, 0);
  endtask

  task automatic t_errors_no_auto();
    do_reset();
    auto_resync_dis_i = 1'b1;
    send_prbs(52, 0);
    send_prbs(64, 10); settle();
    check("R9", "lock kept with auto off", 32'(in_sync_o), 1);
    latch(1, "R7", 64, 10);
  endtask

  task automatic t_auto_drop();
    do_reset();
    send_prbs(52, 0);
    send_prbs(64, 5); settle();
    check("R9", "5 errors keep lock", 32'(in_sync_o), 1);
    send_prbs(5, 5); settle();
    check("R9", "5 errors new window", 32'(in_sync_o), 1);
    send_prbs(1, 1); settle();
    check("R9", "6th error drops lock", 32'(in_sync_o), 0);
    latch(0, "R7", 70, 11);
    send_prbs(10, 0);
    latch(0, "R7", 0, 0);
  endtask

  task automatic t_manual();
    do_reset();
    send_prbs(52, 0); settle();
    resync_ctl_i = 1'b1; @(negedge clk);
    check("R10", "resync drops lock", 32'(in_sync_o), 0);
    send_prbs(51, 0); settle();
    check("R10", "reacquiring at 51", 32'(in_sync_o), 0);
    send_prbs(1, 0); settle();
    check("R10", "relock at 52 with control held", 32'(in_sync_o), 1);
    resync_ctl_i = 1'b0; @(negedge clk);
  endtask

  task automatic t_loopback();
    do_reset();
    loopback_i = 1'b1;
    send_prbs(52, 0); settle();
    check("R1", "lock on tx stream", 32'(in_sync_o), 1);
    send_prbs(40, 0);
    latch(1, "R1", 40, 0);
  endtask

  task automatic t_capture();
    logic [31:0] snap;
    do_reset();
    send_prbs(45, 0); settle();
    load_ctl_pin_i = 1'b1; @(negedge clk);
    check("R2", "capture history", rx_capture_o, sent_hist);
    snap = sent_hist;
    load_ctl_reg_i = 1'b1;
    send_prbs(8, 0); settle(); @(negedge clk);
    check("R4", "held load no recapture", rx_capture_o, snap);
    load_ctl_pin_i = 0; load_ctl_reg_i = 0; @(negedge clk);
    load_ctl_reg_i = 1'b1; @(negedge clk);
    check("R2", "recapture after rearm", rx_capture_o, sent_hist);
    load_ctl_reg_i = 1'b0; @(negedge clk);
  endtask

  task automatic t_repeat();
    do_reset();
    prbs_sel_i = 1'b0;
    send_rep(63); settle();
    check("R6", "no lock after 63", 32'(in_sync_o), 0);
    send_rep(1); settle();
    check("R6", "lock after 64", 32'(in_sync_o), 1);
    send_rep(32);
    latch(1, "R6", 32, 0);
  endtask

  task automatic t_gap();
    do_reset();
    send_prbs(52, 0);
    send_prbs(10, 0);
    settle();
    for (int i = 0; i < 15; i++) begin
      @(negedge clk); rx_data_i = i[0];
    end
    check("R12", "lock held over gap", 32'(in_sync_o), 1);
    send_prbs(10, 0);
    latch(0, "R12", 20, 0);
  endtask

  task automatic t_saturate();
    do_reset();
    auto_resync_dis_i = 1'b1;
    send_prbs(52, 0);
    send_prbs(300, 300);
    latch(1, "R8", 255, 255);
  endtask

  initial begin
    t_reset();
    t_prbs_latch();
    t_errors_no_auto();
    t_auto_drop();
    t_manual();
    t_loopback();
    t_capture();
    t_repeat();
    t_gap();
    t_saturate();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule